// File: doc/BRIEF.md
# NAND Flash Command Interface

This block is the device-side front end of an asynchronous byte-wide NAND-style memory. It samples the host's write strobe on the internal clock. On each rising write strobe, with chip enable low, it takes the bus byte as a command when the command-latch line is high and the address-latch line is low. It takes the byte as an address when the address-latch line is high and the command-latch line is low. From those bytes it keeps track of what a read strobe should return: nothing (array data belongs to a path outside this block), the live status byte, or the identification bytes.

A small countdown timer stands in for array activity. An array read with an address byte holds the device busy for a fixed number of cycles. A reset command holds it busy for its own interval, cutting short any activity already running. The ready/busy output follows that timer. A reset command that arrives while the device is still in its reset state, meaning no other recognised command has been taken since the last reset, is dropped.

Top module: `nand_cmd_if`

## Requirements
- R1: A byte is taken only on a rising edge of `we_n` while `ce_n` is low. It is a command when `cle`=1 and `ale`=0, and an address when `ale`=1 and `cle`=0. Any other combination, or `ce_n` high, leaves the block unchanged.
- R2: Command 70h selects status mode. While `ce_n` and `re_n` are both low, the block drives `io_oe`=1 with the status byte. Otherwise `io_oe`=0.
- R3: The status byte is bit 7 = `wp_n`, bits 6 and 5 = 1 when not busy, and bits 4..0 = 0. When ready it reads E0h with `wp_n` high and 60h with `wp_n` low. When busy it reads 80h with `wp_n` high.
- R4: During one unbroken read cycle in status mode, the driven status changes from busy to ready when the timer expires, with no new strobe.
- R5: A selected output mode stays in force over any number of read cycles until a new command is taken. Commands 00h and 50h select array-read mode, in which the block does not drive the bus.
- R6: Command 90h followed by address 00h selects ID mode. Successive reads give ADh, then the `DEV_CODE` parameter, then 00h for every later read. A non-zero address after 90h selects nothing and the bus stays undriven. A fresh 90h/00h pair restarts the sequence at ADh.
- R7: An address byte in array-read mode holds `rb_n` low for exactly `T_READ` cycles.
- R8: Command FFh, outside the reset state, holds `rb_n` low for exactly `T_RST` cycles and returns the block to idle with no bus output. Command 70h is still taken during that interval and reports 80h.
- R9: FFh taken while an array read is busy aborts it. `rb_n` rises `T_RST` cycles after the reset, not when the read would have finished.
- R10: FFh received in the reset state (after power-on reset or a taken FFh, with no other recognised command since) is ignored, and `rb_n` stays high.
- R11: Command codes other than 00h, 50h, 70h, 90h and FFh are ignored, and the current mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low, reflected in status bit 7 |
| io_in | input | 8 | Bus byte from host |
| io_out | output | 8 | Bus byte to host |
| io_oe | output | 1 | Bus drive enable |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
The bench sweeps every command code out of status mode. A decoder that mistook an unknown code for a real one would drop status output or change it. It measures the exact busy length after a read and after a reset, and issues a reset part-way through a read. A design that failed to reload the timer would release `rb_n` too late. It holds one read strobe low across the end of a busy period, which exposes a status byte captured only at the strobe edge. It also repeats resets and runs ID reads past the second byte with bad and doubly-qualified addresses. Those cases expose a missing reset-state guard, a wrapping ID index, or an address decoder that ignores a qualifier.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
  typedef enum logic [2:0] {
    MD_IDLE,
    MD_READ,
    MD_STATUS,
    MD_IDWAIT,
    MD_ID
  } mode_e;

  localparam logic [7:0] OP_READ_A = 8'h00;
  localparam logic [7:0] OP_READ_B = 8'h50;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_RESET  = 8'hFF;
  localparam logic [7:0] MAKER_ID  = 8'hAD;
  localparam int         ID_LAST   = 2;
endpackage

// File: rtl/nand_strobe_det.sv
module nand_strobe_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  output logic cmd_wr,
  output logic addr_wr,
  output logic rd_done
);
  logic we_q, re_q;
  logic we_rise, re_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  always_comb begin
    we_rise = ~we_q & we_n & ~ce_n;
    re_rise = ~re_q & re_n & ~ce_n;
    cmd_wr  = we_rise & cle & ~ale;
    addr_wr = we_rise & ale & ~cle;
    rd_done = re_rise;
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && addr_wr)); // R1
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int T_RST  = 24,
  parameter int T_READ = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_rst,
  input  logic start_read,
  output logic busy
);
  localparam int CMAX = (T_RST > T_READ) ? T_RST : T_READ;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (start_rst)
      cnt_n = CW'(T_RST);
    else if (start_read)
      cnt_n = CW'(T_READ);
    else if (cnt != '0)
      cnt_n = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign busy = (cnt != '0);

  AST_RST_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_rst |=> busy); // R8
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_rst && !start_read) |=> (cnt == $past(cnt) - CW'(1))); // R7
endmodule

// File: rtl/nand_mode_fsm.sv
module nand_mode_fsm
  import nand_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       addr_wr,
  input  logic       rd_done,
  input  logic [7:0] din,
  input  logic       busy,
  output mode_e      mode,
  output logic [1:0] id_idx,
  output logic       start_rst,
  output logic       start_read
);
  mode_e      mode_n;
  logic [1:0] idx_n;
  logic       in_rst, in_rst_n;

  always_comb begin
    mode_n     = mode;
    idx_n      = id_idx;
    in_rst_n   = in_rst;
    start_rst  = 1'b0;
    start_read = 1'b0;
    if (cmd_wr) begin
      case (din)
        OP_RESET: begin
          if (!in_rst) begin
            start_rst = 1'b1;
            mode_n    = MD_IDLE;
            in_rst_n  = 1'b1;
          end
        end
        OP_READ_A, OP_READ_B: begin
          mode_n   = MD_READ;
          in_rst_n = 1'b0;
        end
        OP_STATUS: begin
          mode_n   = MD_STATUS;
          in_rst_n = 1'b0;
        end
        OP_IDENT: begin
          mode_n   = MD_IDWAIT;
          in_rst_n = 1'b0;
        end
        default: ;
      endcase
    end else if (addr_wr) begin
      if (mode == MD_READ)
        start_read = 1'b1;
      if (mode == MD_IDWAIT && din == 8'h00) begin
        mode_n = MD_ID;
        idx_n  = 2'd0;
      end
    end else if (rd_done && mode == MD_ID && id_idx != 2'(ID_LAST)) begin
      idx_n = id_idx + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MD_IDLE;
      id_idx <= 2'd0;
      in_rst <= 1'b1;
    end else begin
      mode   <= mode_n;
      id_idx <= idx_n;
      in_rst <= in_rst_n;
    end
  end

  AST_ID_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    id_idx <= 2'(ID_LAST)); // R6
  AST_REPEAT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && din == OP_RESET && in_rst && !busy) |=> !busy); // R10
endmodule

// File: rtl/nand_out_mux.sv
module nand_out_mux
  import nand_cmd_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h73
) (
  input  mode_e      mode,
  input  logic [1:0] id_idx,
  input  logic       busy,
  input  logic       wp_n,
  input  logic       ce_n,
  input  logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe
);
  logic [7:0] status_byte, id_byte;
  logic       rd_cycle;

  always_comb begin
    status_byte = {wp_n, ~busy, ~busy, 5'b00000};
    case (id_idx)
      2'd0:    id_byte = MAKER_ID;
      2'd1:    id_byte = DEV_CODE;
      default: id_byte = 8'h00;
    endcase
    rd_cycle = ~ce_n & ~re_n;
    io_oe    = rd_cycle & ((mode == MD_STATUS) | (mode == MD_ID));
    if (mode == MD_ID)          io_out = id_byte;
    else if (mode == MD_STATUS) io_out = status_byte;
    else                        io_out = 8'h00;
  end
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
  import nand_cmd_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h73,
  parameter int         T_RST    = 24,
  parameter int         T_READ   = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb_n
);
  logic       cmd_wr, addr_wr, rd_done;
  logic       start_rst, start_read, busy;
  logic [1:0] id_idx;
  mode_e      mode;

  nand_strobe_det u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n),
    .cmd_wr(cmd_wr), .addr_wr(addr_wr), .rd_done(rd_done)
  );

  nand_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .addr_wr(addr_wr),
    .rd_done(rd_done), .din(io_in), .busy(busy),
    .mode(mode), .id_idx(id_idx),
    .start_rst(start_rst), .start_read(start_read)
  );

  nand_busy_timer #(.T_RST(T_RST), .T_READ(T_READ)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_rst(start_rst),
    .start_read(start_read), .busy(busy)
  );

  nand_out_mux #(.DEV_CODE(DEV_CODE)) u_mux (
    .mode(mode), .id_idx(id_idx), .busy(busy), .wp_n(wp_n),
    .ce_n(ce_n), .re_n(re_n), .io_out(io_out), .io_oe(io_oe)
  );

  assign rb_n = ~busy;

  AST_STATUS_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && mode == MD_STATUS) |-> (io_out[6] == rb_n)); // R4
  AST_STATUS_WP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && mode == MD_STATUS) |-> (io_out[7] == wp_n && io_out[4:0] == 5'b0)); // R3
  AST_RST_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_rst |=> (!io_oe && !rb_n)); // R8
endmodule

// File: tb/nand_cmd_if_bench.sv
module nand_cmd_if_bench;
  localparam logic [7:0] DEV = 8'h73;
  localparam int TR = 24;
  localparam int TD = 40;

  logic clk = 1'b0;
  logic rst_n, ce_n, cle, ale, we_n, re_n, wp_n;
  logic [7:0] io_in, io_out;
  logic io_oe, rb_n;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nand_cmd_if #(.DEV_CODE(DEV), .T_RST(TR), .T_READ(TD)) u_nand_cmd_if (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; io_in = d; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1;
  endtask

  task automatic rd(output logic [7:0] d, output logic oe);
    @(negedge clk);
    re_n = 1'b0;
    @(negedge clk);
    d = io_out; oe = io_oe;
    re_n = 1'b1;
  endtask

  task automatic count_low(output int n);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (rb_n) break;
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int n;
    rst_n = 1'b0; ce_n = 1'b0; cle = 1'b0; ale = 1'b0; we_n = 1'b1;
    re_n = 1'b1; wp_n = 1'b1; io_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset rb_n", rb_n, 1);
    chk("reset io_oe", io_oe, 0);

    // R10: reset right after power-on is ignored
    wr(1, 0, 8'hFF); count_low(n);
    chk("R10 power-on FFh", n, 0);

    // R2, R3, R5: status mode
    wr(1, 0, 8'h70);
    for (int i = 0; i < 3; i++) begin
      rd(d, oe);
      chk("R2 status oe", oe, 1);
      chk("R5 status persists", d, 8'hE0);
    end
    @(negedge clk);
    chk("R2 bus released with re_n high", io_oe, 0);
    wp_n = 1'b0; rd(d, oe);
    chk("R3 status wp low", d, 8'h60);
    wp_n = 1'b1;

    // R1: deselected write ignored
    @(negedge clk); ce_n = 1'b1;
    wr(1, 0, 8'h90);
    @(negedge clk); ce_n = 1'b0;
    rd(d, oe);
    chk("R1 ce_n high ignored", {oe, d}, {1'b1, 8'hE0});

    // R11/R5: sweep every non-reset code out of status mode
    for (int c = 0; c < 255; c++) begin
      wr(1, 0, 8'h70);
      wr(1, 0, 8'(c));
      rd(d, oe);
      if (c == 8'h00 || c == 8'h50 || c == 8'h90)
        chk("R5 R6 code selects non-status", oe, 0);
      else
        chk("R11 unknown code keeps status", {oe, d}, {1'b1, 8'hE0});
    end

    // R6 and R1: ID sequence
    wr(1, 0, 8'h90);
    wr(1, 1, 8'h00); rd(d, oe);
    chk("R1 cle+ale address ignored", oe, 0);
    wr(0, 1, 8'h05); rd(d, oe);
    chk("R6 nonzero address no ID", oe, 0);
    wr(0, 1, 8'h00);
    rd(d, oe); chk("R6 maker byte", {oe, d}, {1'b1, 8'hAD});
    rd(d, oe); chk("R6 device byte", {oe, d}, {1'b1, DEV});
    rd(d, oe); chk("R6 third byte", {oe, d}, {1'b1, 8'h00});
    rd(d, oe); chk("R6 fourth byte", {oe, d}, {1'b1, 8'h00});
    wr(1, 0, 8'h90); wr(0, 1, 8'h00);
    rd(d, oe); chk("R6 restart", d, 8'hAD);

    // R7: array read busy length
    wr(1, 0, 8'h00); wr(0, 1, 8'h12); count_low(n);
    chk("R7 read busy cycles", n, TD);
    rd(d, oe); chk("R5 array mode undriven", oe, 0);

    // R8: reset length, idle after, status during reset busy
    wr(1, 0, 8'h70); wr(1, 0, 8'hFF); count_low(n);
    chk("R8 reset busy cycles", n, TR);
    rd(d, oe); chk("R8 idle after reset", oe, 0);
    wr(1, 0, 8'h70); wr(1, 0, 8'hFF); wr(1, 0, 8'h70);
    rd(d, oe); chk("R8 status while resetting", d, 8'h80);
    count_low(n);
    rd(d, oe); chk("R3 status ready", d, 8'hE0);

    // R4: live status within one read cycle
    wr(1, 0, 8'h00); wr(0, 1, 8'h01); wr(1, 0, 8'h70);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk);
    chk("R4 busy seen", {io_oe, io_out}, {1'b1, 8'h80});
    for (int k = 0; k < 100 && !rb_n; k++) @(negedge clk);
    chk("R4 ready seen without strobe", {io_oe, io_out}, {1'b1, 8'hE0});
    re_n = 1'b1;

    // R9: abort of a busy read
    wr(1, 0, 8'h00); wr(0, 1, 8'h02);
    repeat (5) @(negedge clk);
    wr(1, 0, 8'hFF); count_low(n);
    chk("R9 abort releases after reset time", n, TR);

    // R10: second reset in reset state ignored
    wr(1, 0, 8'hFF); count_low(n);
    chk("R10 repeated FFh", n, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule